// File: doc/BRIEF.md
# I2C Own-Address Slave Receiver

This block is the receive half of a slave node on a two-wire serial bus. It samples the clock and data lines with the system clock and finds START and STOP conditions. After each START it shifts in the first byte. It compares the upper seven bits of that byte with a programmed node address. When the address matches, the direction bit shows a write, and acknowledging is enabled, the node pulls the data line low for the acknowledge slot and then receives data bytes. Each data byte is answered with an ACK or a NACK, according to the acknowledge-enable input at the moment the byte completes.

After every event that software must handle, the block raises an interrupt flag and posts a status code. It then keeps the clock line low, stretching the bus, until software pulses the clear input. Software can detach the node at run time by dropping acknowledge-enable: the bus is still tracked, but the node's own address is no longer answered. A separate input reports that this node's own master attempt lost arbitration. The status code that follows then tells software that the node is now being addressed as a slave after that loss.

The controller runs as a state machine with these states:
- `ST_IDLE`: the bus is free or the node is disabled.
- `ST_ADDR`: the address byte is being shifted in.
- `ST_AACK`: the address acknowledge slot is being driven.
- `ST_DATA`: a data byte is being shifted in.
- `ST_DACK`: the data acknowledge or not-acknowledge slot.
- `ST_HOLD`: the interrupt flag is set and the clock is stretched.
- `ST_SKIP`: the node is not addressed and waits for the next START or STOP.

The transitions are:
- START: to `ST_ADDR` from any state other than `ST_HOLD`. From `ST_DATA` or `ST_DACK` it first posts A0h and passes through `ST_HOLD`.
- STOP: to `ST_IDLE`. From `ST_DATA` or `ST_DACK` it first posts A0h and passes through `ST_HOLD`.
- `ST_ADDR` to `ST_AACK` or `ST_SKIP`: on the clock fall after the eighth bit.
- `ST_AACK` to `ST_HOLD`: on the clock fall that ends the slot.
- `ST_DATA` to `ST_DACK`: on the clock fall after the eighth bit.
- `ST_DACK` to `ST_HOLD`: on the clock fall that ends the slot.
- `ST_HOLD` to the stored successor: when software clears the flag. The successor is `ST_DATA`, `ST_SKIP`, `ST_IDLE` or `ST_ADDR`.
- Any state to `ST_IDLE`: when the enable input is low.

Top module: `i2c_addr_slave_rx`

## Requirements
- R1: After reset, `irq` is 0, `status` is F8h, and neither `scl_drive_low` nor `sda_drive_low` is asserted.
- R2: When the first byte after a START carries `own_addr` in bits 7..1, has 0 (write) in bit 0, and `ack_en`=1, the block pulls SDA low during the ninth clock. After that clock falls, it sets `irq` with status 60h.
- R3: While `irq` is 1, `scl_drive_low` is 1. `irq` stays set until `si_clr` is pulsed, and `scl_drive_low` is then released.
- R4: A data byte received while addressed, with `ack_en`=1 when its eighth bit completes, is acknowledged. It posts status 80h, and `rx_data` holds the byte (MSB first on the wire).
- R5: If `ack_en` is 0 when a data byte completes, the block leaves SDA high in the ninth clock and posts 88h. After the flag is cleared it ignores further bytes until the next START.
- R6: An address byte with a different address, or with the node's address and bit 0 = 1 (read) when no arbitration loss is pending, is not acknowledged and sets no flag.
- R7: While `ack_en`=0, the node's own write address is neither acknowledged nor flagged. After `ack_en` returns to 1, the node's address is recognised again at the next START.
- R8: After a pulse on `arb_lost`, an own-address write is acknowledged and posts 68h instead of 60h.
- R9: After a pulse on `arb_lost`, an own-address read is acknowledged and posts B0h. Once the flag is cleared, the block ignores the bus until the next START or STOP.
- R10: A STOP or a repeated START seen while addressed as a receiver posts A0h. After a repeated START, the following address byte is recognised as in R2.
- R11: While `enable`=0, the block drives neither line and never sets `irq`.
- R12: `status` reads F8h whenever `irq` is 0. Each rise of `irq` shows one of 60h, 68h, 80h, 88h, A0h or B0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable |
| ack_en | input | 1 | Acknowledge enable; 0 detaches the node |
| own_addr | input | 7 | Node address compared with byte bits 7..1 |
| arb_lost | input | 1 | Pulse: own master attempt lost arbitration |
| si_clr | input | 1 | Pulse: software clears the interrupt flag |
| scl_i | input | 1 | Sensed bus clock line |
| sda_i | input | 1 | Sensed bus data line |
| scl_drive_low | output | 1 | Pull bus clock low (stretching) |
| sda_drive_low | output | 1 | Pull bus data low (acknowledge) |
| irq | output | 1 | Interrupt flag |
| status | output | 8 | Status code, F8h when no flag is set |
| rx_data | output | 8 | Last received data byte |

## Verification
The properties assume the following about the bus:
- Each SCL phase and each SDA change lasts several system clocks longer than the synchroniser delay, so edges and conditions are seen exactly once.
- `ack_en` is steady around the clock fall on which an acknowledge is decided.
- `si_clr` is pulsed only while the flag is being serviced.

The bench stays within these assumptions in three ways:
- Its bit-banged master holds each quarter bit for eight clocks.
- It waits for the wired clock line to rise before it continues, so stretching is honoured.
- It changes `ack_en` and `enable` only between bytes, while the clock line is low.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_DATA,
        ST_DACK,
        ST_HOLD,
        ST_SKIP
    } slv_state_t;

    typedef enum logic [1:0] {
        NX_IDLE,
        NX_ADDR,
        NX_DATA,
        NX_SKIP
    } slv_next_t;

    localparam logic [7:0] CODE_NONE     = 8'hF8;
    localparam logic [7:0] CODE_OWN_W    = 8'h60;
    localparam logic [7:0] CODE_ARB_W    = 8'h68;
    localparam logic [7:0] CODE_DAT_ACK  = 8'h80;
    localparam logic [7:0] CODE_DAT_NACK = 8'h88;
    localparam logic [7:0] CODE_END      = 8'hA0;
    localparam logic [7:0] CODE_ARB_R    = 8'hB0;

    function automatic slv_state_t resume_state(slv_next_t nx);
        slv_state_t s;
        unique case (nx)
            NX_IDLE: s = ST_IDLE;
            NX_ADDR: s = ST_ADDR;
            NX_DATA: s = ST_DATA;
            NX_SKIP: s = ST_SKIP;
            default: s = ST_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/i2c_slv_linemon.sv
module i2c_slv_linemon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_now
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_pipe;
    logic [LAST:0] sda_pipe;
    logic          scl_prev;
    logic          sda_prev;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_pipe[g] <= scl_i;
                    sda_pipe[g] <= sda_i;
                end else begin
                    scl_pipe[g] <= scl_pipe[(g == 0) ? 0 : g - 1];
                    sda_pipe[g] <= sda_pipe[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_pipe[LAST];
            sda_prev <= sda_pipe[LAST];
        end
    end

    assign scl_rise  =  scl_pipe[LAST] & ~scl_prev;
    assign scl_fall  = ~scl_pipe[LAST] &  scl_prev;
    assign start_det =  scl_pipe[LAST] &  scl_prev & sda_prev & ~sda_pipe[LAST];
    assign stop_det  =  scl_pipe[LAST] &  scl_prev & ~sda_prev & sda_pipe[LAST];
    assign sda_now   =  sda_pipe[LAST];

endmodule

// File: rtl/i2c_slv_shreg.sv
module i2c_slv_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] data,
    output logic         full
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(W);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            cnt  <= '0;
        end else if (clr) begin
            cnt  <= '0;
        end else if (shift_en && cnt != CNT_FULL) begin
            data <= {data[W-2:0], bit_in};
            cnt  <= cnt + 1'b1;
        end
    end

    assign full = (cnt == CNT_FULL);

endmodule

// File: rtl/i2c_addr_slave_rx.sv
module i2c_addr_slave_rx
    import i2c_slv_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ack_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              arb_lost,
    input  logic              si_clr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic              irq,
    output logic [7:0]        status,
    output logic [ADDR_W:0]   rx_data
);
    localparam int BYTE_W = ADDR_W + 1;

    logic scl_rise, scl_fall, start_det, stop_det, sda_now;
    logic sh_clr, sh_en, sh_full;
    logic [BYTE_W-1:0] sh_data;

    slv_state_t state_q, state_d;
    slv_next_t  hold_nx_q, hold_nx_d;
    logic [7:0] code_q, si_code, pend_q, pend_d;
    logic       set_si, cap_byte, ack_q, ack_d, arb_q, arb_clr;
    logic       addressed, addr_hit, dir_read;

    i2c_slv_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_now   (sda_now)
    );

    i2c_slv_shreg #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sh_clr),
        .shift_en (sh_en),
        .bit_in   (sda_now),
        .data     (sh_data),
        .full     (sh_full)
    );

    assign sh_en     = scl_rise && (state_q == ST_ADDR || state_q == ST_DATA);
    assign addressed = (state_q == ST_DATA) || (state_q == ST_DACK);
    assign addr_hit  = (sh_data[BYTE_W-1:1] == own_addr);
    assign dir_read  = sh_data[0];

    // next-state and event decode
    always_comb begin
        state_d   = state_q;
        hold_nx_d = hold_nx_q;
        pend_d    = pend_q;
        ack_d     = ack_q;
        si_code   = code_q;
        set_si    = 1'b0;
        cap_byte  = 1'b0;
        sh_clr    = 1'b0;
        arb_clr   = 1'b0;
        if (!enable) begin
            state_d = ST_IDLE;
            sh_clr  = 1'b1;
        end else if (state_q == ST_HOLD) begin
            if (si_clr) begin
                state_d = resume_state(hold_nx_q);
                sh_clr  = 1'b1;
            end
        end else if (start_det) begin
            sh_clr = 1'b1;
            if (addressed) begin
                set_si    = 1'b1;
                si_code   = CODE_END;
                hold_nx_d = NX_ADDR;
                state_d   = ST_HOLD;
            end else begin
                state_d = ST_ADDR;
            end
        end else if (stop_det) begin
            sh_clr = 1'b1;
            if (addressed) begin
                set_si    = 1'b1;
                si_code   = CODE_END;
                hold_nx_d = NX_IDLE;
                state_d   = ST_HOLD;
            end else begin
                state_d = ST_IDLE;
            end
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP, ST_HOLD: begin
                end
                ST_ADDR: begin
                    if (scl_fall && sh_full) begin
                        sh_clr = 1'b1;
                        if (ack_en && addr_hit && (!dir_read || arb_q)) begin
                            state_d = ST_AACK;
                            pend_d  = dir_read ? CODE_ARB_R
                                               : (arb_q ? CODE_ARB_W : CODE_OWN_W);
                        end else begin
                            state_d = ST_SKIP;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        set_si    = 1'b1;
                        si_code   = pend_q;
                        hold_nx_d = (pend_q == CODE_ARB_R) ? NX_SKIP : NX_DATA;
                        arb_clr   = 1'b1;
                        state_d   = ST_HOLD;
                    end
                end
                ST_DATA: begin
                    if (scl_fall && sh_full) begin
                        sh_clr   = 1'b1;
                        cap_byte = 1'b1;
                        ack_d    = ack_en;
                        state_d  = ST_DACK;
                    end
                end
                ST_DACK: begin
                    if (scl_fall) begin
                        set_si    = 1'b1;
                        si_code   = ack_q ? CODE_DAT_ACK : CODE_DAT_NACK;
                        hold_nx_d = ack_q ? NX_DATA : NX_SKIP;
                        state_d   = ST_HOLD;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq       <= 1'b0;
            code_q    <= CODE_NONE;
            pend_q    <= CODE_NONE;
            hold_nx_q <= NX_IDLE;
            ack_q     <= 1'b0;
            arb_q     <= 1'b0;
            rx_data   <= '0;
        end else begin
            pend_q    <= pend_d;
            hold_nx_q <= hold_nx_d;
            ack_q     <= ack_d;
            if (cap_byte) rx_data <= sh_data;
            if (!enable) begin
                irq <= 1'b0;
            end else if (set_si) begin
                irq    <= 1'b1;
                code_q <= si_code;
            end else if (state_q == ST_HOLD && si_clr) begin
                irq <= 1'b0;
            end
            if (!enable || arb_clr || stop_det) arb_q <= 1'b0;
            else if (arb_lost)                  arb_q <= 1'b1;
        end
    end

    assign status        = irq ? code_q : CODE_NONE;
    assign scl_drive_low = (state_q == ST_HOLD);
    assign sda_drive_low = (state_q == ST_AACK) || (state_q == ST_DACK && ack_q);

endmodule

// File: rtl/i2c_addr_slave_rx_chk.sv
module i2c_addr_slave_rx_chk #(
    parameter int ADDR_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            ack_en,
    input logic            si_clr,
    input logic            scl_drive_low,
    input logic            sda_drive_low,
    input logic            irq,
    input logic [7:0]      status,
    input logic [ADDR_W:0] rx_data
);
    // R3: flag persists until software clears it
    p_flag_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !si_clr |=> irq);

    // R3: clock is stretched for as long as the flag is up
    p_stretch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> scl_drive_low);

    // R12: every new flag carries a legal code
    p_code_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (status inside {8'h60, 8'h68, 8'h80, 8'h88, 8'hA0, 8'hB0}));

    // R11: disabled block is silent on the bus
    p_quiet_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sda_drive_low && !scl_drive_low && !irq));

    // R5: acknowledge only when enabled at the decision point
    p_ack_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> $past(ack_en));

    // R4: received byte stays put while software reads it
    p_rx_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !si_clr |=> $stable(rx_data));

endmodule

bind i2c_addr_slave_rx i2c_addr_slave_rx_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .ack_en        (ack_en),
    .si_clr        (si_clr),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .irq           (irq),
    .status        (status),
    .rx_data       (rx_data)
);

// File: tb/test_i2c_addr_slave_rx.sv
module test_i2c_addr_slave_rx;

    localparam int Q = 8;
    localparam logic [6:0] OWN = 7'h3A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, ack_en = 1'b0, arb_lost = 1'b0, si_clr = 1'b0;
    logic [6:0] own_addr = OWN;
    logic scl_m_low = 1'b0, sda_m_low = 1'b0;
    logic scl_drive_low, sda_drive_low, irq;
    logic [7:0] status, rx_data;
    wire scl_bus = ~(scl_m_low | scl_drive_low);
    wire sda_bus = ~(sda_m_low | sda_drive_low);

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    i2c_addr_slave_rx i_i2c_addr_slave_rx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ack_en(ack_en),
        .own_addr(own_addr), .arb_lost(arb_lost), .si_clr(si_clr),
        .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .irq(irq), .status(status), .rx_data(rx_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (scl_bus !== 1'b1) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m_low = 1'b0; idle(Q);
        scl_m_low = 1'b0; wait_scl_high(); idle(Q);
        sda_m_low = 1'b1; idle(Q);
        scl_m_low = 1'b1; idle(Q);
    endtask

    task automatic m_stop();
        sda_m_low = 1'b1; idle(Q);
        scl_m_low = 1'b0; wait_scl_high(); idle(Q);
        sda_m_low = 1'b0; idle(Q);
    endtask

    task automatic m_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m_low = ~b[i]; idle(Q);
            scl_m_low = 1'b0; wait_scl_high(); idle(Q);
            scl_m_low = 1'b1; idle(Q);
        end
        sda_m_low = 1'b0; idle(Q);
        scl_m_low = 1'b0; wait_scl_high(); idle(Q);
        acked = ~sda_bus;
        scl_m_low = 1'b1; idle(Q);
    endtask

    task automatic clear_si();
        si_clr = 1'b1; idle(1); si_clr = 1'b0; idle(2);
    endtask

    task automatic expect_flag(input string tag, input logic [7:0] code);
        int t = 0;
        while (irq !== 1'b1 && t < 200) begin idle(1); t++; end
        check({tag, " irq"}, irq, 1);
        check({tag, " status"}, status, code);
        check({tag, " stretch"}, scl_drive_low, 1);
    endtask

    task automatic expect_none(input string tag);
        idle(10);
        check({tag, " no irq"}, irq, 0);
        check({tag, " idle status"}, status, 8'hF8);
    endtask

    // R1
    task automatic t_reset();
        check("R1 irq", irq, 0);
        check("R1 status", status, 8'hF8);
        check("R1 scl drive", scl_drive_low, 0);
        check("R1 sda drive", sda_drive_low, 0);
    endtask

    // R2 R3 R4 R10 (stop)
    task automatic t_basic_write();
        logic a;
        m_start();
        m_byte({OWN, 1'b0}, a);
        check("R2 addr ack", a, 1);
        expect_flag("R2", 8'h60);
        idle(20);
        check("R3 still held", scl_drive_low, 1);
        check("R3 flag kept", irq, 1);
        clear_si();
        check("R3 released", scl_drive_low, 0);
        check("R3 flag cleared", status, 8'hF8);
        m_byte(8'hC5, a);
        check("R4 data ack", a, 1);
        expect_flag("R4", 8'h80);
        check("R4 rx_data", rx_data, 8'hC5);
        clear_si();
        m_byte(8'h3C, a);
        check("R4 second ack", a, 1);
        expect_flag("R4 b2", 8'h80);
        check("R4 rx_data b2", rx_data, 8'h3C);
        clear_si();
        m_stop();
        expect_flag("R10 stop", 8'hA0);
        clear_si();
        check("R10 stop released", scl_drive_low, 0);
    endtask

    // R5
    task automatic t_nack_midway();
        logic a;
        m_start();
        m_byte({OWN, 1'b0}, a);
        expect_flag("R5 addr", 8'h60);
        clear_si();
        m_byte(8'h11, a);
        expect_flag("R5 first", 8'h80);
        ack_en = 1'b0;
        clear_si();
        m_byte(8'h22, a);
        check("R5 nack", a, 0);
        expect_flag("R5", 8'h88);
        check("R5 rx_data", rx_data, 8'h22);
        clear_si();
        ack_en = 1'b1;
        m_byte(8'h33, a);
        check("R5 ignored ack", a, 0);
        expect_none("R5 ignored");
        m_stop();
        expect_none("R5 stop");
    endtask

    // R6
    task automatic t_not_mine();
        logic a;
        m_start();
        m_byte({OWN ^ 7'h01, 1'b0}, a);
        check("R6 other addr nack", a, 0);
        expect_none("R6 other");
        m_stop();
        m_start();
        m_byte({OWN, 1'b1}, a);
        check("R6 read nack", a, 0);
        expect_none("R6 read");
        m_stop();
    endtask

    // R7
    task automatic t_detach();
        logic a;
        ack_en = 1'b0;
        m_start();
        m_byte({OWN, 1'b0}, a);
        check("R7 detached nack", a, 0);
        expect_none("R7 detached");
        m_stop();
        ack_en = 1'b1;
        m_start();
        m_byte({OWN, 1'b0}, a);
        check("R7 reattach ack", a, 1);
        expect_flag("R7", 8'h60);
        clear_si();
        m_stop();
        expect_flag("R7 stop", 8'hA0);
        clear_si();
    endtask

    // R8 R9
    task automatic t_arb();
        logic a;
        arb_lost = 1'b1; idle(1); arb_lost = 1'b0;
        m_start();
        m_byte({OWN, 1'b0}, a);
        check("R8 ack", a, 1);
        expect_flag("R8", 8'h68);
        clear_si();
        m_byte(8'h5A, a);
        expect_flag("R8 data", 8'h80);
        check("R8 rx_data", rx_data, 8'h5A);
        clear_si();
        m_stop();
        expect_flag("R8 stop", 8'hA0);
        clear_si();
        arb_lost = 1'b1; idle(1); arb_lost = 1'b0;
        m_start();
        m_byte({OWN, 1'b1}, a);
        check("R9 ack", a, 1);
        expect_flag("R9", 8'hB0);
        clear_si();
        idle(10);
        check("R9 bus free", sda_drive_low, 0);
        m_stop();
        expect_none("R9 after");
    endtask

    // R10 repeated start
    task automatic t_restart();
        logic a;
        m_start();
        m_byte({OWN, 1'b0}, a);
        expect_flag("R10 addr", 8'h60);
        clear_si();
        m_byte(8'h99, a);
        expect_flag("R10 data", 8'h80);
        clear_si();
        m_start();
        expect_flag("R10 restart", 8'hA0);
        clear_si();
        m_byte({OWN, 1'b0}, a);
        check("R10 readdress ack", a, 1);
        expect_flag("R10 readdress", 8'h60);
        clear_si();
        m_stop();
        expect_flag("R10 end", 8'hA0);
        clear_si();
    endtask

    // R11
    task automatic t_disabled();
        logic a;
        enable = 1'b0; idle(2);
        m_start();
        m_byte({OWN, 1'b0}, a);
        check("R11 nack", a, 0);
        check("R11 scl drive", scl_drive_low, 0);
        expect_none("R11");
        m_stop();
        enable = 1'b1; idle(2);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(3);
        t_reset();
        enable = 1'b1;
        ack_en = 1'b1;
        idle(5);
        t_basic_write();
        t_nack_midway();
        t_not_mine();
        t_detach();
        t_arb();
        t_restart();
        t_disabled();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule